// File: doc/BRIEF.md
# Masked Broadcast Configuration Register File

This block is a write-only store of configuration settings for four transceiver channels. A host writes one 8-bit bank per cycle through a 4-bit address, an 8-bit data bus and a write strobe. Twelve of the sixteen banks belong to the channels, three to each: receiver static, transmitter static and dynamic. Three global banks copy a write into the matching bank of every channel that accepts broadcasts. The last bank holds a bit mask that limits which bit positions any later write may change.

A channel bank takes part in a broadcast when its own enable bit (bit 0) is set. It also takes part when the force bit (bit 0) of the global bank being written is set. Bit 1 of each dynamic bank drives an active-low phase-align reset pulse. That bit returns to 1 by itself, so software never has to write the 1 back. All channel bank contents are presented flat on one output bus.

Top module: `cfg_bcast_regfile`

## Requirements
- R1: While reset is held, the channel banks of every channel read 8'hBF, 8'hB3 and 8'hAD for roles 0, 1 and 2, the mask reads 8'hFF and the global banks read 8'h00.
- R2: A write to address c*3+r (c = channel 0..3, r = role 0..2) changes only channel bank c*3+r, and the new value shows on the output after the clock edge that samples the write.
- R3: A write to address 12+r updates role r of every channel whose stored bank bit 0 is 1 before that edge.
- R4: A channel bank whose bit 0 is 0 ignores a broadcast unless bit 0 of the global bank's new value (after masking) is 1, in which case it is updated like any other.
- R5: A write to address 15 stores its data into the mask with no masking. A later write to any other address changes only the bit positions whose mask bit is 1.
- R6: The mask also limits the bits that a broadcast delivers to channel banks and the bits stored in the global bank itself.
- R7: Bit 1 of each dynamic bank (role 2) becomes 1 on every clock edge that does not accept a write into that bank. pa_rst_n[c] equals that bit of channel c, so writing 0 there gives a low pulse of exactly one cycle.
- R8: cfg_out carries channel bank k (k = c*3+r) on bits [k*8+7 : k*8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Bank address |
| wr_data | input | 8 | Write data |
| cfg_out | output | 96 | Flat contents of the twelve channel banks |
| pa_rst_n | output | 4 | Active-low phase-align reset pulse per channel |

## Verification
Every bank is a single register stage. A write sampled at clock edge N, whether direct, broadcast or to the mask, shows on cfg_out and pa_rst_n right after edge N. A pulse bit written to 0 returns to 1 after edge N+1. The bench drives its inputs on the falling edge and updates its behavioural model at the rising edge. It compares all outputs on the next falling edge, so each result is checked in the half-cycle after the edge that produced it. Directed checks made straight after a write task returns, and one cycle later for the pulse, sample in the same cycles.

// File: rtl/cfg_bcast_pkg.sv
package cfg_bcast_pkg;

   typedef enum int {
      ROLE_RX_STATIC = 0,
      ROLE_TX_STATIC = 1,
      ROLE_DYNAMIC   = 2
   } bank_role_e;

   function automatic int chan_bank_index(input int ch, input int role, input int per_ch);
      return ch * per_ch + role;
   endfunction

endpackage

// File: rtl/cfg_mask_reg.sv
module cfg_mask_reg #(
   parameter int              DW      = 8,
   parameter logic [DW-1:0]   RST_VAL = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] mask
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask <= RST_VAL;
      else if (hit)
         mask <= wr_data;
   end

endmodule

// File: rtl/cfg_global_bank.sv
module cfg_global_bank #(
   parameter int            DW      = 8,
   parameter int            EN_BIT  = 0,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit,
   input  logic [DW-1:0] mask,
   input  logic [DW-1:0] wr_data,
   output logic          force_now
);

   logic [DW-1:0] q;
   logic [DW-1:0] merged;

   always_comb merged = (q & ~mask) | (wr_data & mask);

   assign force_now = hit & merged[EN_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (hit)
         q <= merged;
   end

endmodule

// File: rtl/cfg_chan_bank.sv
module cfg_chan_bank #(
   parameter int            DW        = 8,
   parameter int            EN_BIT    = 0,
   parameter int            PULSE_BIT = 1,
   parameter bit            SELF_CLR  = 1'b0,
   parameter logic [DW-1:0] RST_VAL   = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] mask,
   input  logic [DW-1:0] wr_data,
   input  logic          direct_hit,
   input  logic          gbl_hit,
   input  logic          gbl_force,
   output logic [DW-1:0] q
);

   localparam logic [DW-1:0] PSEL = SELF_CLR ? (DW'(1) << PULSE_BIT) : '0;

   logic          take;
   logic [DW-1:0] merged;
   logic [DW-1:0] nxt;

   always_comb begin
      take   = direct_hit | (gbl_hit & (q[EN_BIT] | gbl_force));
      merged = (q & ~mask) | (wr_data & mask);
      nxt    = take ? merged : q;
   end

   generate
      if (SELF_CLR) begin : g_selfclr
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= RST_VAL;
            else
               q <= take ? nxt : (nxt | PSEL);
         end

         AST_PULSE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
            !take |=> q[PULSE_BIT]);  // R7
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= RST_VAL;
            else
               q <= nxt;
         end
      end
   endgenerate

   AST_MASKED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (((q ^ $past(q)) & ~$past(mask) & ~PSEL) == '0));  // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!direct_hit && !gbl_hit) |=> ((q & ~PSEL) == ($past(q) & ~PSEL)));  // R2

   AST_BCAST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (gbl_hit && !direct_hit && !q[EN_BIT] && !gbl_force)
         |=> ((q & ~PSEL) == ($past(q) & ~PSEL)));  // R4

endmodule

// File: rtl/cfg_bcast_regfile.sv
module cfg_bcast_regfile #(
   parameter int  NUM_CH       = 4,
   parameter int  BANKS_PER_CH = 3,
   parameter int  DW           = 8,
   parameter int  AW           = 4,
   parameter int  EN_BIT       = 0,
   parameter int  PULSE_BIT    = 1,
   parameter int  PULSE_ROLE   = 2,
   parameter logic [BANKS_PER_CH*DW-1:0] RST_ROLES = 24'hADB3BF,
   parameter logic [DW-1:0] RST_GLOBAL = '0,
   parameter logic [DW-1:0] RST_MASK   = '1,
   localparam int CH_BANKS  = NUM_CH * BANKS_PER_CH,
   localparam int OUT_W     = CH_BANKS * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   output logic [OUT_W-1:0]  cfg_out,
   output logic [NUM_CH-1:0] pa_rst_n
);

   import cfg_bcast_pkg::*;

   localparam int GBL_BASE  = CH_BANKS;
   localparam int MASK_IDX  = CH_BANKS + BANKS_PER_CH;
   localparam int NUM_BANKS = 1 << AW;

   generate
      if (MASK_IDX + 1 != NUM_BANKS) begin : g_bad_map
         $error("address space must hold channel, global and mask banks exactly");
      end
      if (EN_BIT >= DW || PULSE_BIT >= DW || EN_BIT == PULSE_BIT) begin : g_bad_bits
         $error("enable and pulse bit positions must be distinct and inside a bank");
      end
      if (PULSE_ROLE >= BANKS_PER_CH) begin : g_bad_role
         $error("pulse role must name an existing bank role");
      end
   endgenerate

   logic [NUM_BANKS-1:0]    hit;
   logic [DW-1:0]           mask;
   logic [BANKS_PER_CH-1:0] g_force;

   always_comb begin
      hit = '0;
      if (wr_en)
         hit[wr_addr] = 1'b1;
   end

   cfg_mask_reg #(.DW(DW), .RST_VAL(RST_MASK)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit[MASK_IDX]),
      .wr_data (wr_data),
      .mask    (mask)
   );

   genvar r, c;
   generate
      for (r = 0; r < BANKS_PER_CH; r++) begin : g_gbl
         cfg_global_bank #(.DW(DW), .EN_BIT(EN_BIT), .RST_VAL(RST_GLOBAL)) u_gbl (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (hit[GBL_BASE + r]),
            .mask      (mask),
            .wr_data   (wr_data),
            .force_now (g_force[r])
         );
      end

      for (c = 0; c < NUM_CH; c++) begin : g_ch
         for (r = 0; r < BANKS_PER_CH; r++) begin : g_role
            localparam int IDX = chan_bank_index(c, r, BANKS_PER_CH);
            logic [DW-1:0] q;

            cfg_chan_bank #(
               .DW        (DW),
               .EN_BIT    (EN_BIT),
               .PULSE_BIT (PULSE_BIT),
               .SELF_CLR  (r == PULSE_ROLE),
               .RST_VAL   (RST_ROLES[r*DW +: DW])
            ) u_bank (
               .clk        (clk),
               .rst_n      (rst_n),
               .mask       (mask),
               .wr_data    (wr_data),
               .direct_hit (hit[IDX]),
               .gbl_hit    (hit[GBL_BASE + r]),
               .gbl_force  (g_force[r]),
               .q          (q)
            );

            assign cfg_out[IDX*DW +: DW] = q;

            if (r == PULSE_ROLE) begin : g_pulse
               assign pa_rst_n[c] = q[PULSE_BIT];
            end
         end
      end
   endgenerate

endmodule

// File: tb/sim_cfg_bcast_regfile.sv
`timescale 1ns/1ps
module sim_cfg_bcast_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [95:0] cfg_out;
   logic [3:0]  pa_rst_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;
   string cur_req = "R1";

   logic [7:0] m_bank [12];
   logic [7:0] m_gbl  [3];
   logic [7:0] m_mask;
   logic [7:0] m_old  [12];
   bit         m_tk   [12];

   always #2 clk = ~clk;

   cfg_bcast_regfile u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cfg_out(cfg_out), .pa_rst_n(pa_rst_n)
   );

   function automatic logic [7:0] mrg(input logic [7:0] o, input logic [7:0] d, input logic [7:0] m);
      return (o & ~m) | (d & m);
   endfunction

   task automatic model_reset();
      for (int c = 0; c < 4; c++) begin
         m_bank[c*3+0] = 8'hBF;
         m_bank[c*3+1] = 8'hB3;
         m_bank[c*3+2] = 8'hAD;
      end
      for (int r = 0; r < 3; r++) m_gbl[r] = 8'h00;
      m_mask = 8'hFF;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         m_old = m_bank;
         for (int k = 0; k < 12; k++) m_tk[k] = 1'b0;
         if (wr_en) begin
            if (wr_addr == 4'd15) begin
               m_mask = wr_data;
            end else if (wr_addr < 4'd12) begin
               m_bank[wr_addr] = mrg(m_old[wr_addr], wr_data, m_mask);
               m_tk[wr_addr] = 1'b1;
            end else begin
               int r;
               r = int'(wr_addr) - 12;
               m_gbl[r] = mrg(m_gbl[r], wr_data, m_mask);
               for (int c = 0; c < 4; c++) begin
                  if (m_old[c*3+r][0] || m_gbl[r][0]) begin
                     m_bank[c*3+r] = mrg(m_old[c*3+r], wr_data, m_mask);
                     m_tk[c*3+r] = 1'b1;
                  end
               end
            end
         end
         for (int c = 0; c < 4; c++)
            if (!m_tk[c*3+2]) m_bank[c*3+2][1] = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         for (int k = 0; k < 12; k++) begin
            n_cmp++;
            if (cfg_out[k*8 +: 8] !== m_bank[k]) begin
               n_bad++;
               $display("FAIL %s bank %0d: actual %h expected %h", cur_req, k, cfg_out[k*8 +: 8], m_bank[k]);
            end
         end
         for (int c = 0; c < 4; c++) begin
            n_cmp++;
            if (pa_rst_n[c] !== m_bank[c*3+2][1]) begin
               n_bad++;
               $display("FAIL R7 pa_rst_n[%0d]: actual %b expected %b", c, pa_rst_n[c], m_bank[c*3+2][1]);
            end
         end
      end
   end

   task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [7:0] bank_of(input int k);
      return cfg_out[k*8 +: 8];
   endfunction

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp_on = 1'b1;
      // R1 and R8: reset layout, bank k at bits k*8
      chk("R1", cfg_out, {4{24'hADB3BF}});
      chk("R8", {88'h0, bank_of(5)}, {88'h0, 8'hAD});
      chk("R1", {92'h0, pa_rst_n}, 96'h0);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R7";
      chk("R7", {92'h0, pa_rst_n}, 96'hF);
      chk("R7", {88'h0, bank_of(8)}, {88'h0, 8'hAF});

      cur_req = "R2";
      wr(4'd4, 8'h5A);
      chk("R2", {88'h0, bank_of(4)}, {88'h0, 8'h5A});
      chk("R2", {88'h0, bank_of(3)}, {88'h0, 8'hBF});

      cur_req = "R3";
      wr(4'd12, 8'h3D);
      for (int c = 0; c < 4; c++) chk("R3", {88'h0, bank_of(c*3)}, {88'h0, 8'h3D});

      cur_req = "R4";
      wr(4'd3, 8'h10);
      wr(4'd12, 8'hE2);
      chk("R4", {88'h0, bank_of(3)}, {88'h0, 8'h10});
      chk("R4", {88'h0, bank_of(0)}, {88'h0, 8'hE2});
      wr(4'd12, 8'h66);
      chk("R4", {88'h0, bank_of(6)}, {88'h0, 8'hE2});
      wr(4'd12, 8'h77);
      for (int c = 0; c < 4; c++) chk("R4", {88'h0, bank_of(c*3)}, {88'h0, 8'h77});

      cur_req = "R5";
      wr(4'd15, 8'h02);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'h00;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7", {92'h0, pa_rst_n}, 96'hE);
      chk("R5", {88'h0, bank_of(2)}, {88'h0, 8'hAD});
      @(negedge clk);
      chk("R7", {92'h0, pa_rst_n}, 96'hF);
      wr(4'd1, 8'h00);
      chk("R5", {88'h0, bank_of(1)}, {88'h0, 8'hB1});

      cur_req = "R6";
      wr(4'd15, 8'hF0);
      wr(4'd13, 8'h5F);
      chk("R6", {88'h0, bank_of(1)}, {88'h0, 8'h51});
      chk("R6", {88'h0, bank_of(10)}, {88'h0, 8'h53});

      cur_req = "R7";
      wr(4'd15, 8'hFF);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd14; wr_data = 8'h0D;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7", {92'h0, pa_rst_n}, 96'h0);
      @(negedge clk);
      chk("R7", {92'h0, pa_rst_n}, 96'hF);
      chk("R3", {88'h0, bank_of(11)}, {88'h0, 8'h0F});

      cur_req = "R5";
      wr(4'd15, 8'h00);
      wr(4'd7, 8'h12);
      chk("R5", {88'h0, bank_of(7)}, {88'h0, 8'h53});
      wr(4'd15, 8'hFF);

      cur_req = "R2";
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         wr_en   = 1'($urandom_range(0, 1));
         wr_addr = 4'($urandom_range(0, 15));
         wr_data = 8'($urandom);
      end
      @(negedge clk);
      wr_en = 1'b0;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule